// File: doc/BRIEF.md
# Analog Window Watchdog Monitor

This block sits beside an analog-to-digital converter and inspects every finished conversion result. When a monitored result lies outside a programmed window (above an upper limit or below a lower limit), it raises a sticky status flag. The flag can also be routed to an interrupt request line. The comparison uses the raw 12-bit result exactly as it leaves the converter, before any data alignment or offset is applied.

Monitoring can be switched on separately for the regular and the injected conversion groups. It can cover every channel, or only one selected channel. Software configures the block through a simple write port with four registers.

Software clears the flag by writing a zero to its bit. Writing a one to that bit leaves the flag as it is.

Register addresses on `wr_addr`:
- 0: upper limit.
- 1: lower limit.
- 2: control. Bits [4:0] hold the selected channel, bit 5 enables single-channel mode, bit 6 enables regular monitoring, bit 7 enables injected monitoring and bit 8 enables the interrupt.
- 3: status. Bit 0 is the flag.

Top module: `awd_monitor`

## Requirements
- R1: Writes to the upper limit (address 0) and the lower limit (address 1) keep only `wr_data[11:0]`; the upper bits are discarded.
- R2: One clock after a monitored result is presented with `res_vld`=1, `awd_flag` is 1 if the value is strictly greater than the upper limit or strictly less than the lower limit. A value equal to either limit does not set it, and nothing happens while `res_vld`=0.
- R3: A result with `res_inj`=0 (regular) is monitored only when control bit 6 is 1. A result with `res_inj`=1 (injected) is monitored only when control bit 7 is 1.
- R4: With control bits 6 and 7 both 0, the flag never sets, whatever the results.
- R5: With control bit 5 = 1, only results whose `res_chan` equals the selected channel (control bits [4:0]) are monitored. With bit 5 = 0, every channel is monitored.
- R6: In single-channel mode with both group enables set, the same selected channel is monitored in both the regular and the injected group.
- R7: A control write whose channel field exceeds MAX_CHAN (default 17) stores channel 0 instead; the other control bits are still written.
- R8: A write to address 3 with bit 0 = 0 clears the flag, and a write with bit 0 = 1 leaves it unchanged. If a new out-of-window hit arrives in the same cycle as a clear, the flag stays set. Otherwise the flag holds its value.
- R9: `awd_irq` equals `awd_flag` AND control bit 8.
- R10: After reset the flag and the interrupt are 0, all enables are 0, the upper limit is 0xFFF and the lower limit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_vld | input | 1 | Conversion result strobe |
| res_inj | input | 1 | 1 = injected group, 0 = regular group |
| res_chan | input | 5 | Channel number of the result |
| res_data | input | 12 | Raw conversion value |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 upper, 1 lower, 2 control, 3 status) |
| wr_data | input | 16 | Register write data |
| awd_flag | output | 1 | Sticky out-of-window flag |
| awd_irq | output | 1 | Interrupt request |

## Verification
Results are presented exactly at each limit and one step beyond it. This separates a strict comparison from an inclusive one. An upper limit is written with set upper bits, which shows whether the 12-bit mask is applied.

The same out-of-window value is sent on matching and non-matching channels, and in both groups under each enable combination. This separates the channel filter from the group filter. An out-of-range channel select is written, then followed by traffic on channel 0 and on the rejected channel.

Clear writes with bit 0 at one and at zero, and a clear that lands in the same cycle as a hit, show the clear semantics and which event takes priority.

// File: rtl/awd_pkg.sv
// Shared register addresses and control bit positions for the window watchdog.
package awd_pkg;
    typedef enum logic [1:0] {
        AWD_A_HIGH = 2'd0,
        AWD_A_LOW  = 2'd1,
        AWD_A_CTRL = 2'd2,
        AWD_A_STAT = 2'd3
    } awd_addr_e;

    localparam int CTL_SINGLE = 5;
    localparam int CTL_REG_EN = 6;
    localparam int CTL_INJ_EN = 7;
    localparam int CTL_IRQ_EN = 8;
    localparam int STAT_FLAG  = 0;
endpackage

// File: rtl/awd_cfg_regs.sv
// Configuration registers of the window watchdog.
// Holds both limits, the channel select, the mode and enable bits, and
// decodes status clear requests. Assumes WR_W > CTL_IRQ_EN and WR_W >= DATA_W.
module awd_cfg_regs
    import awd_pkg::*;
#(
    parameter int DATA_W   = 12,
    parameter int CHAN_W   = 5,
    parameter int WR_W     = 16,
    parameter int MAX_CHAN = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    output logic [DATA_W-1:0] hi_lim,
    output logic [DATA_W-1:0] lo_lim,
    output logic [CHAN_W-1:0] sel_chan,
    output logic              single_md,
    output logic              reg_en,
    output logic              inj_en,
    output logic              irq_en,
    output logic              clr_req
);
    localparam logic [CHAN_W-1:0] SEL_MAX = CHAN_W'(MAX_CHAN);

    logic [CHAN_W-1:0] wr_chan;

    // Channel field of the write data, replaced by zero when out of range.
    always_comb begin
        wr_chan = wr_data[CHAN_W-1:0];
        if (wr_chan > SEL_MAX) wr_chan = '0;
    end

    // Register update on writes to the limit and control addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_lim    <= '1;
            lo_lim    <= '0;
            sel_chan  <= '0;
            single_md <= 1'b0;
            reg_en    <= 1'b0;
            inj_en    <= 1'b0;
            irq_en    <= 1'b0;
        end else if (wr_en) begin
            case (awd_addr_e'(wr_addr))
                AWD_A_HIGH: hi_lim <= wr_data[DATA_W-1:0];
                AWD_A_LOW:  lo_lim <= wr_data[DATA_W-1:0];
                AWD_A_CTRL: begin
                    sel_chan  <= wr_chan;
                    single_md <= wr_data[CTL_SINGLE];
                    reg_en    <= wr_data[CTL_REG_EN];
                    inj_en    <= wr_data[CTL_INJ_EN];
                    irq_en    <= wr_data[CTL_IRQ_EN];
                end
                default: ;
            endcase
        end
    end

    // A status write with a zero in the flag bit requests a clear.
    assign clr_req = wr_en && (wr_addr == AWD_A_STAT) && !wr_data[STAT_FLAG];

    AST_SEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == AWD_A_CTRL && wr_data[CHAN_W-1:0] > SEL_MAX)
        |=> (sel_chan == '0)) else $error("select not rejected"); // R7
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_chan <= SEL_MAX) else $error("select out of range"); // R7
endmodule

// File: rtl/awd_window_cmp.sv
// Group and channel filter plus window comparison on the raw result.
// Produces a one-cycle hit when a monitored result falls outside the limits.
// Assumes res_data is the unaligned converter output.
module awd_window_cmp #(
    parameter int DATA_W = 12,
    parameter int CHAN_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_vld,
    input  logic              res_inj,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [DATA_W-1:0] res_data,
    input  logic [DATA_W-1:0] hi_lim,
    input  logic [DATA_W-1:0] lo_lim,
    input  logic [CHAN_W-1:0] sel_chan,
    input  logic              single_md,
    input  logic              reg_en,
    input  logic              inj_en,
    output logic              hit
);
    logic grp_ok;
    logic chan_ok;
    logic outside;

    // Select the enable that belongs to the result's group.
    assign grp_ok  = res_inj ? inj_en : reg_en;
    // In single-channel mode accept only the selected channel.
    assign chan_ok = !single_md || (res_chan == sel_chan);
    // Strict comparison against both limits.
    assign outside = (res_data > hi_lim) || (res_data < lo_lim);
    // Combine the qualifiers into the hit strobe.
    assign hit     = res_vld && grp_ok && chan_ok && outside;

    AST_NO_HIT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_en && !inj_en) |-> !hit) else $error("hit while disabled"); // R4
    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (res_data <= hi_lim && res_data >= lo_lim) |-> !hit)
        else $error("hit inside window"); // R2
endmodule

// File: rtl/awd_status.sv
// Sticky watchdog flag with write-zero-to-clear and interrupt gating.
// A hit in the same cycle as a clear wins.
module awd_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic clr_req,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    // Flag update: set on hit, clear on request, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag <= 1'b0;
        else if (hit)     flag <= 1'b1;
        else if (clr_req) flag <= 1'b0;
    end

    // Interrupt request gated by its enable.
    assign irq = flag & irq_en;

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag) else $error("hit lost"); // R8
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag) else $error("flag dropped"); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !hit) |=> !flag) else $error("clear ignored"); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag && irq_en)) else $error("ungated irq"); // R9
endmodule

// File: rtl/awd_monitor.sv
// Top level of the analog window watchdog.
// Connects configuration registers, window comparator and status flag.
// Assumes one result per cycle at most, marked by res_vld.
module awd_monitor #(
    parameter int DATA_W   = 12,
    parameter int CHAN_W   = 5,
    parameter int WR_W     = 16,
    parameter int MAX_CHAN = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_vld,
    input  logic              res_inj,
    input  logic [CHAN_W-1:0] res_chan,
    input  logic [DATA_W-1:0] res_data,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    output logic              awd_flag,
    output logic              awd_irq
);
    logic [DATA_W-1:0] hi_lim;
    logic [DATA_W-1:0] lo_lim;
    logic [CHAN_W-1:0] sel_chan;
    logic              single_md;
    logic              reg_en;
    logic              inj_en;
    logic              irq_en;
    logic              clr_req;
    logic              hit;

    awd_cfg_regs #(
        .DATA_W(DATA_W), .CHAN_W(CHAN_W), .WR_W(WR_W), .MAX_CHAN(MAX_CHAN)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hi_lim(hi_lim), .lo_lim(lo_lim),
        .sel_chan(sel_chan), .single_md(single_md), .reg_en(reg_en),
        .inj_en(inj_en), .irq_en(irq_en), .clr_req(clr_req)
    );

    awd_window_cmp #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_inj(res_inj),
        .res_chan(res_chan), .res_data(res_data), .hi_lim(hi_lim),
        .lo_lim(lo_lim), .sel_chan(sel_chan), .single_md(single_md),
        .reg_en(reg_en), .inj_en(inj_en), .hit(hit)
    );

    awd_status u_stat (
        .clk(clk), .rst_n(rst_n), .hit(hit), .clr_req(clr_req),
        .irq_en(irq_en), .flag(awd_flag), .irq(awd_irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!awd_flag && !awd_irq)) else $error("not quiet after reset"); // R10
endmodule

// File: tb/awd_monitor_tb.sv
// Directed bench for the window watchdog; one task per scenario.
module awd_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_vld, res_inj;
    logic [4:0]  res_chan;
    logic [11:0] res_data;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic        awd_flag, awd_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    awd_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_inj(res_inj),
        .res_chan(res_chan), .res_data(res_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .awd_flag(awd_flag),
        .awd_irq(awd_irq)
    );

    // Control word: chan[4:0], single bit5, reg bit6, inj bit7, irq bit8.
    function automatic logic [15:0] ctl(input int ch, input bit sgl,
                                        input bit re, input bit ie_inj,
                                        input bit irq);
        return 16'(ch) | (16'(sgl) << 5) | (16'(re) << 6) |
               (16'(ie_inj) << 7) | (16'(irq) << 8);
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic res(input bit inj, input int ch, input int val);
        @(negedge clk);
        res_vld = 1'b1; res_inj = inj; res_chan = 5'(ch); res_data = 12'(val);
        @(negedge clk);
        res_vld = 1'b0;
    endtask

    task automatic clr();
        wr(2'd3, 16'h0000);
    endtask

    task automatic t_reset();
        check("R10 flag", awd_flag, 1'b0);
        check("R10 irq", awd_irq, 1'b0);
        res(1'b0, 0, 12'hFFF);
        check("R10 disabled after reset", awd_flag, 1'b0);
    endtask

    task automatic t_window();
        wr(2'd0, 16'hF800);            // R1: upper limit becomes 0x800
        wr(2'd1, 16'h0100);
        wr(2'd2, ctl(0, 0, 1, 0, 1));
        res(1'b0, 3, 12'h800);
        check("R2 equal upper", awd_flag, 1'b0);
        @(negedge clk); res_vld = 1'b0; res_data = 12'hFFF; res_chan = 5'd3;
        @(negedge clk);
        check("R2 no strobe", awd_flag, 1'b0);
        res(1'b0, 3, 12'h801);
        check("R1 masked upper limit", awd_flag, 1'b1);
        check("R9 irq enabled", awd_irq, 1'b1);
        wr(2'd3, 16'h0001);
        check("R8 write one keeps", awd_flag, 1'b1);
        clr();
        check("R8 write zero clears", awd_flag, 1'b0);
        res(1'b0, 9, 12'h100);
        check("R2 equal lower", awd_flag, 1'b0);
        res(1'b0, 9, 12'h0FF);
        check("R2 below lower", awd_flag, 1'b1);
        clr();
    endtask

    task automatic t_groups();
        res(1'b1, 2, 12'hFFF);
        check("R3 injected disabled", awd_flag, 1'b0);
        wr(2'd2, ctl(0, 0, 0, 1, 1));
        res(1'b0, 2, 12'h000);
        check("R3 regular disabled", awd_flag, 1'b0);
        res(1'b1, 2, 12'hFFF);
        check("R3 injected enabled", awd_flag, 1'b1);
        clr();
        wr(2'd2, ctl(0, 0, 0, 0, 1));
        res(1'b0, 1, 12'hFFF);
        res(1'b1, 1, 12'h000);
        check("R4 both disabled", awd_flag, 1'b0);
    endtask

    task automatic t_single();
        wr(2'd2, ctl(5, 1, 1, 1, 1));
        res(1'b0, 4, 12'hFFF);
        check("R5 other channel ignored", awd_flag, 1'b0);
        res(1'b0, 5, 12'hFFF);
        check("R5 selected channel", awd_flag, 1'b1);
        clr();
        res(1'b1, 4, 12'h000);
        check("R6 injected other channel", awd_flag, 1'b0);
        res(1'b1, 5, 12'h000);
        check("R6 injected selected channel", awd_flag, 1'b1);
        clr();
    endtask

    task automatic t_reject();
        wr(2'd2, ctl(20, 1, 1, 0, 1));
        res(1'b0, 20, 12'hFFF);
        check("R7 rejected channel", awd_flag, 1'b0);
        res(1'b0, 0, 12'hFFF);
        check("R7 channel zero", awd_flag, 1'b1);
    endtask

    task automatic t_irq_gate();
        wr(2'd2, ctl(0, 0, 1, 0, 0));
        check("R9 flag still set", awd_flag, 1'b1);
        check("R9 irq gated", awd_irq, 1'b0);
    endtask

    task automatic t_race();
        wr(2'd2, ctl(0, 0, 1, 0, 1));
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0000;
        res_vld = 1'b1; res_inj = 1'b0; res_chan = 5'd7; res_data = 12'hFFF;
        @(negedge clk);
        wr_en = 1'b0; res_vld = 1'b0;
        check("R8 hit beats clear", awd_flag, 1'b1);
        clr();
        check("R8 clear after race", awd_flag, 1'b0);
    endtask

    initial begin
        rst_n = 1'b0; res_vld = 1'b0; res_inj = 1'b0; res_chan = '0;
        res_data = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_window();
        t_groups();
        t_single();
        t_reject();
        t_irq_gate();
        t_race();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule